// File: doc/BRIEF.md
# Flash Cache Control Registers with Tag Flush Walker

This block is the software-visible control point of a flash read cache. It keeps three control bits (cache enable, error-on-bad-write, memory power-down), accepts a flush command, reports flush progress in a status word, and keeps two saturating event counters: one for all cache accesses and one for accesses served from cached data. Software reaches it through a small word-addressed register port with a request/ready handshake.

A flush is carried out by a walker that visits every tag line in turn and drives the tag memory's clear port. Only the valid bits in the tag store are cleared; the data store is never touched by this block. The walk runs by itself whenever reset is released and again each time software asks for it. A read of the flush word is held off until the walk is over, so a single read serves as a wait-for-flush.

The data store, the flash interface and the cache lookup are outside this block. Hit and access events come in as one-cycle pulses from the lookup logic.

Top module: `cache_ctl_regs`

## Requirements
- R1: Control word is at word address 0, with enable at bit 0, bad-write-error at bit 1 and power-down at bit 2. After reset it reads 1, 0 and 0 in those bits, and the three bits also appear on their own output ports.
- R2: A write to the control word stores bits 1 and 2 as written and stores enable as written bit 0 AND NOT written bit 2, so that enable is never 1 while power-down is 1.
- R3: A write to word address 1 with bit 0 set starts a flush walk when none is running. The walk raises the tag clear strobe for exactly LINES consecutive cycles, with the line index going 0, 1, ... LINES-1 in that order.
- R4: A flush walk starts on its own in the first cycle after reset is released.
- R5: Word address 2 is the status word. Its bit 0 reads 0 while a walk is running and 1 otherwise. The flush_busy output is high exactly while a walk runs.
- R6: A read of word address 1 is not answered while a walk runs. It completes after the walk has ended and returns zero.
- R7: A flush write made while a walk runs is ignored and does not restart or lengthen the walk. A write to word 1 with bit 0 clear starts no walk.
- R8: The access counter at word address 4 counts each cycle with evt_access high. It stops at its all-ones value of CNT_W bits and reads zero-extended to 32 bits.
- R9: The hit counter at word address 3 counts each cycle with evt_hit high. It saturates in the same way.
- R10: Any write to a counter word clears that counter to zero. In the cycle of the write, the clear takes priority over a coincident event.
- R11: A request is accepted on a rising edge where bus_req is high, bus_ready is low and no stall applies. bus_ready is then high for exactly the following cycle, with read data valid on bus_rdata in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Register access request, held until bus_ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| evt_access | input | 1 | One cache access happened this cycle |
| evt_hit | input | 1 | One access was served from cached data |
| tag_clr_en | output | 1 | Clear the valid bit of the tag line given by tag_clr_idx |
| tag_clr_idx | output | IDX_W | Tag line index being cleared |
| cache_en | output | 1 | Cache enable bit |
| badwrite_err | output | 1 | Error-on-bad-write bit |
| power_down | output | 1 | Cache memories powered down |
| flush_busy | output | 1 | Flush walk in progress |

## Verification
The assertions check on every cycle that power-down and enable are never both high, that the walk steps by one line per cycle and stops after the last line, that it begins right after reset, that a stalled flush read gets no ready, that ready is a single-cycle pulse, that a saturated counter stays at its maximum and that a cleared counter reads zero. Only the bench scenarios can show the register contents after each of the eight control write values, the exact number of clears and the set of lines visited for a software flush, that a second flush request does not stretch a walk, and the counter values after sweeps of event patterns, including the clear that coincides with an event.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int unsigned BUS_AW = 3;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] WA_CTRL  = 3'd0;
  localparam logic [BUS_AW-1:0] WA_FLUSH = 3'd1;
  localparam logic [BUS_AW-1:0] WA_STAT  = 3'd2;
  localparam logic [BUS_AW-1:0] WA_HITS  = 3'd3;
  localparam logic [BUS_AW-1:0] WA_ACCS  = 3'd4;

  // control word layout, low bit first: enable, bad-write error, power-down
  typedef struct packed {
    logic pwr_dn;
    logic bad_wr;
    logic enable;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pwr_dn: 1'b0, bad_wr: 1'b0, enable: 1'b1};

endpackage

// File: rtl/cc_flush_walker.sv
module cc_flush_walker #(
  parameter int LINES = 64,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] line_idx
);

  localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(LINES - 1);

  // reset leaves the walker busy at line 0, so a walk follows every reset
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      line_idx <= '0;
    end else if (busy) begin
      if (line_idx == LAST_LINE) begin
        busy     <= 1'b0;
        line_idx <= '0;
      end else begin
        line_idx <= line_idx + 1'b1;
      end
    end else if (start) begin
      busy     <= 1'b1;
      line_idx <= '0;
    end
  end

endmodule

// File: rtl/cc_sat_counter.sv
module cc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import cc_pkg::*;
#(
  parameter int LINES = 64,
  parameter int CNT_W = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic              evt_access,
  input  logic              evt_hit,
  output logic              tag_clr_en,
  output logic [IDX_W-1:0]  tag_clr_idx,
  output logic              cache_en,
  output logic              badwrite_err,
  output logic              power_down,
  output logic              flush_busy
);

  localparam int NCNT = 2;

  ctrl_t            ctrl_q;
  logic             stall;
  logic             accept;
  logic             wr_acc;
  logic             rd_acc;
  logic             flush_go;
  logic             walk_busy;
  logic [IDX_W-1:0] walk_idx;
  logic [NCNT-1:0]  cnt_clr;
  logic [NCNT-1:0]  cnt_evt;
  logic [CNT_W-1:0] cnt_val [NCNT];
  logic [31:0]      rd_next;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata[31:3];

  // handshake: a flush read is held off while the walk runs
  assign stall    = bus_req && !bus_wr && (bus_addr == WA_FLUSH) && walk_busy;
  assign accept   = bus_req && !bus_ready && !stall;
  assign wr_acc   = accept && bus_wr;
  assign rd_acc   = accept && !bus_wr;
  assign flush_go = wr_acc && (bus_addr == WA_FLUSH) && bus_wdata[0];

  cc_flush_walker #(.LINES(LINES)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .start    (flush_go),
    .busy     (walk_busy),
    .line_idx (walk_idx)
  );

  assign tag_clr_en  = walk_busy;
  assign tag_clr_idx = walk_idx;
  assign flush_busy  = walk_busy;

  // counter 0 counts hits, counter 1 counts accesses
  assign cnt_evt = {evt_access, evt_hit};
  assign cnt_clr = {wr_acc && (bus_addr == WA_ACCS),
                    wr_acc && (bus_addr == WA_HITS)};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    cc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (cnt_clr[g]),
      .inc   (cnt_evt[g]),
      .count (cnt_val[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_acc && (bus_addr == WA_CTRL)) begin
      ctrl_q.pwr_dn <= bus_wdata[2];
      ctrl_q.bad_wr <= bus_wdata[1];
      ctrl_q.enable <= bus_wdata[0] && !bus_wdata[2];
    end
  end

  assign cache_en     = ctrl_q.enable;
  assign badwrite_err = ctrl_q.bad_wr;
  assign power_down   = ctrl_q.pwr_dn;

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      WA_CTRL:  rd_next = {29'd0, ctrl_q};
      WA_STAT:  rd_next = {31'd0, !walk_busy};
      WA_HITS:  rd_next = 32'(cnt_val[0]);
      WA_ACCS:  rd_next = 32'(cnt_val[1]);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= accept;
      if (rd_acc) begin
        bus_rdata <= rd_next;
      end
    end
  end

endmodule

// File: rtl/cc_regs_checker.sv
module cc_regs_checker #(
  parameter int LINES = 64,
  parameter int CNT_W = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic             bus_ready,
  input logic             tag_clr_en,
  input logic [IDX_W-1:0] tag_clr_idx,
  input logic             cache_en,
  input logic             power_down,
  input logic             flush_busy,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [1:0]       cnt_clr
);

  localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(LINES - 1);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_PD_KILLS_EN: assert property (@(posedge clk) disable iff (rst)
    power_down |-> !cache_en); // R2

  AST_WALK_STEP: assert property (@(posedge clk) disable iff (rst)
    (tag_clr_en && tag_clr_idx != LAST_LINE) |=>
      (tag_clr_en && tag_clr_idx == $past(tag_clr_idx) + 1'b1)); // R3

  AST_WALK_END: assert property (@(posedge clk) disable iff (rst)
    (tag_clr_en && tag_clr_idx == LAST_LINE) |=> !tag_clr_en); // R7

  AST_BOOT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flush_busy && tag_clr_en && tag_clr_idx == '0)); // R4

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (rst)
    (flush_busy && bus_req && !bus_wr && bus_addr == 3'd1 && !bus_ready) |=> !bus_ready); // R6

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready); // R11

  AST_HIT_SAT: assert property (@(posedge clk) disable iff (rst)
    ($past(hit_cnt) == TOP && !$past(cnt_clr[0])) |-> hit_cnt == TOP); // R9

  AST_ACC_SAT: assert property (@(posedge clk) disable iff (rst)
    ($past(acc_cnt) == TOP && !$past(cnt_clr[1])) |-> acc_cnt == TOP); // R8

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    cnt_clr[0] |=> hit_cnt == '0); // R10

endmodule

bind cache_ctl_regs cc_regs_checker #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_req     (bus_req),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_ready   (bus_ready),
  .tag_clr_en  (tag_clr_en),
  .tag_clr_idx (tag_clr_idx),
  .cache_en    (cache_en),
  .power_down  (power_down),
  .flush_busy  (flush_busy),
  .hit_cnt     (cnt_val[0]),
  .acc_cnt     (cnt_val[1]),
  .cnt_clr     (cnt_clr)
);

// File: tb/cache_ctl_regs_test.sv
module cache_ctl_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int CNT_W = 4;
  localparam int IDX_W = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_req = 1'b0;
  logic             bus_wr = 1'b0;
  logic [2:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_ready;
  logic             evt_access = 1'b0;
  logic             evt_hit = 1'b0;
  logic             tag_clr_en;
  logic [IDX_W-1:0] tag_clr_idx;
  logic             cache_en;
  logic             badwrite_err;
  logic             power_down;
  logic             flush_busy;

  int checks = 0;
  int errors = 0;
  int clr_count = 0;
  logic [LINES-1:0] seen = '0;
  int next_idx = 0;
  logic order_bad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctl_regs #(.LINES(LINES), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .evt_access(evt_access), .evt_hit(evt_hit),
    .tag_clr_en(tag_clr_en), .tag_clr_idx(tag_clr_idx), .cache_en(cache_en),
    .badwrite_err(badwrite_err), .power_down(power_down), .flush_busy(flush_busy)
  );

  // tag clear monitor, sampled just after the falling edge
  always @(negedge clk) begin
    #1;
    if (!rst && tag_clr_en) begin
      if (int'(tag_clr_idx) != next_idx) order_bad = 1'b1;
      seen[tag_clr_idx] = 1'b1;
      clr_count++;
      next_idx = (int'(tag_clr_idx) + 1) % LINES;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    clr_count = 0;
    seen = '0;
    next_idx = 0;
    order_bad = 1'b0;
  endtask

  task automatic xfer(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      output logic [31:0] q, output int waits);
    @(negedge clk);
    bus_req <= 1'b1; bus_wr <= wr; bus_addr <= a; bus_wdata <= d;
    waits = 0;
    do begin
      @(negedge clk); #1;
      waits++;
    end while (!bus_ready && waits < 1000);
    q = bus_rdata;
    bus_req <= 1'b0;
  endtask

  task automatic pulse(input logic acc, input logic hit);
    @(negedge clk);
    evt_access <= acc; evt_hit <= hit;
    @(negedge clk);
    evt_access <= 1'b0; evt_hit <= 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] q;
    int w;
    logic [31:0] exp;

    repeat (3) @(negedge clk);
    mon_clear();
    rst <= 1'b0;
    #1;
    check("R4 busy after reset", {31'd0, flush_busy}, 32'd1);
    check("R1 reset enable port", {31'd0, cache_en}, 32'd1);
    check("R1 reset badwrite port", {31'd0, badwrite_err}, 32'd0);
    check("R1 reset powerdown port", {31'd0, power_down}, 32'd0);
    repeat (LINES + 2) @(negedge clk);
    check("R4 reset walk length", clr_count, LINES);
    check("R4 reset walk lines", {24'd0, seen}, 32'hFF);
    check("R3 reset walk order", {31'd0, order_bad}, 32'd0);
    xfer(1'b0, 3'd0, 32'd0, q, w);
    check("R1 reset control word", q, 32'd1);
    check("R11 ready after one cycle", w, 32'd1);
    xfer(1'b0, 3'd2, 32'd0, q, w);
    check("R5 status idle", q, 32'd1);

    // control word sweep over all written values
    for (int v = 0; v < 8; v++) begin
      xfer(1'b1, 3'd0, 32'(v) | 32'hFFFF_FFF8, q, w);
      exp = {29'd0, v[2], v[1], v[0] & ~v[2]};
      xfer(1'b0, 3'd0, 32'd0, q, w);
      check("R2 control readback", q, exp);
      check("R1 enable port", {31'd0, cache_en}, {31'd0, exp[0]});
      check("R1 badwrite port", {31'd0, badwrite_err}, {31'd0, exp[1]});
      check("R2 powerdown port", {31'd0, power_down}, {31'd0, exp[2]});
    end

    // write with bit 0 clear starts nothing
    mon_clear();
    xfer(1'b1, 3'd1, 32'hFFFF_FFFE, q, w);
    repeat (3) @(negedge clk);
    check("R7 no walk on zero bit", clr_count, 0);

    // software flush, status, stalled read
    mon_clear();
    xfer(1'b1, 3'd1, 32'd1, q, w);
    xfer(1'b0, 3'd2, 32'd0, q, w);
    check("R5 status busy", q, 32'd0);
    check("R5 busy port", {31'd0, flush_busy}, 32'd1);
    xfer(1'b0, 3'd1, 32'd0, q, w);
    check("R6 read held off", {31'd0, w >= LINES - 3}, 32'd1);
    check("R6 walk over at response", {31'd0, flush_busy}, 32'd0);
    check("R6 flush read value", q, 32'd0);
    check("R3 walk length", clr_count, LINES);
    check("R3 walk lines", {24'd0, seen}, 32'hFF);
    check("R3 walk order", {31'd0, order_bad}, 32'd0);
    xfer(1'b0, 3'd2, 32'd0, q, w);
    check("R5 status after walk", q, 32'd1);

    // repeated request during a walk
    mon_clear();
    xfer(1'b1, 3'd1, 32'd1, q, w);
    xfer(1'b1, 3'd1, 32'd1, q, w);
    xfer(1'b1, 3'd1, 32'd1, q, w);
    xfer(1'b0, 3'd1, 32'd0, q, w);
    repeat (2) @(negedge clk);
    check("R7 walk not restarted", clr_count, LINES);
    check("R7 order kept", {31'd0, order_bad}, 32'd0);

    // counter sweep
    for (int n = 0; n < 18; n++) begin
      xfer(1'b1, 3'd3, 32'hDEAD, q, w);
      xfer(1'b1, 3'd4, 32'hBEEF, q, w);
      for (int i = 0; i < n; i++) pulse(1'b1, i[0]);
      xfer(1'b0, 3'd4, 32'd0, q, w);
      check("R8 access count", q, (n > CMAX) ? CMAX : n);
      xfer(1'b0, 3'd3, 32'd0, q, w);
      check("R9 hit count", q, ((n / 2) > CMAX) ? CMAX : (n / 2));
    end

    // hits only: access counter untouched
    xfer(1'b1, 3'd4, 32'd0, q, w);
    xfer(1'b1, 3'd3, 32'd0, q, w);
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1);
    xfer(1'b0, 3'd4, 32'd0, q, w);
    check("R8 access not counted on hit alone", q, 32'd0);
    xfer(1'b0, 3'd3, 32'd0, q, w);
    check("R9 hits alone", q, 32'd5);

    // saturate, then clear with an event in the same cycle
    for (int i = 0; i < CMAX + 3; i++) pulse(1'b1, 1'b1);
    xfer(1'b0, 3'd3, 32'd0, q, w);
    check("R9 saturated", q, CMAX);
    evt_hit <= 1'b1;
    xfer(1'b1, 3'd3, 32'd0, q, w);
    evt_hit <= 1'b0;
    xfer(1'b0, 3'd3, 32'd0, q, w);
    check("R10 clear beats event", q, 32'd0);
    xfer(1'b0, 3'd4, 32'd0, q, w);
    check("R10 other counter kept", q, CMAX);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule